// File: doc/BRIEF.md
# GPIO Bank with Shared Blink Generators

This block is a bank of general-purpose I/O lines behind a simple 32-bit register bus. Each line has its own direction bit, static output value and input polarity bit. The sampled pad inputs go through a two-stage synchroniser. Software reads them after they are XORed with the polarity mask.

Two blink timers, set A and set B, produce square waves whose high and low lengths are programmable in core clock cycles. Any line can drop its static output value and follow the waveform of either timer instead. A per-line select bit picks the timer. Both timers run freely and never stop. A new length written to a timer is picked up only when its current phase ends, so no pulse is ever cut short or stretched. The interrupt cause and mask registers are plain storage only.

Top module: `gpio_blink_bank`

## Requirements
- R1: After reset, every line is an input (`pad_oe` = 0) and `pad_out` = 0. Reads return the following: direction register all ones, every other storage register 0, and all four timer length registers 1.
- R2: The registers sit at these byte addresses on `bus_addr`:
  - 0x00: static output value.
  - 0x04: direction (1 = input, 0 = output).
  - 0x08: blink enable.
  - 0x0C: input polarity.
  - 0x10: input data, read-only.
  - 0x14: edge cause.
  - 0x18 and 0x1C: two mask registers.
  - 0x20: timer select.
  - Set A high and low lengths at 0x30 and 0x34; set B high and low lengths at 0x38 and 0x3C.

  A write takes effect at the rising clock edge on which `bus_wr` is high. `bus_rdata` shows the addressed register without delay. Unmapped addresses read 0.
- R3: `pad_oe[n]` is the inverse of direction bit n, starting from the edge that writes the direction register.
- R4: A line whose blink enable bit is 0 drives its static output bit on `pad_out`, starting from the edge that writes that value.
- R5: The input data register returns the pad value XORed with the polarity register. The pad value passes through two flops first, so a pad change becomes visible after the second rising edge.
- R6: Each timer drives its wave high for its high length in cycles, then low for its low length, and repeats. A stored length of 0 behaves as 1.
- R7: A line with its blink enable bit set follows set A when its select bit is 0 and set B when its select bit is 1.
- R8: A length written in the middle of a phase leaves the current phase at its old length. The new length applies from the next phase of that kind.
- R9: All lines enabled for blinking on the same timer carry identical values on every cycle.
- R10: Writing the edge cause register clears each bit whose written value is 0. A write never sets a bit.
- R11: Writes to the input data address have no effect on what it reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NLINES | Raw pad input levels |
| pad_out | output | NLINES | Pad output levels |
| pad_oe | output | NLINES | Pad output enables, 1 = drive |

## Verification
The checker watches four kinds of behaviour on every cycle:
- the output enables follow each direction write;
- the static output path follows each value write while no blink bit is set;
- all lines sharing a timer stay in phase;
- the synchroniser shows the pad value from two edges earlier, and the edge cause register never gains a bit.

Other behaviour can only be shown by the bench's scenarios:
- the exact high and low lengths of each waveform;
- treating a length of 0 as 1;
- picking up a new length only at the next phase boundary;
- routing each line to its selected timer;
- the read-only input data address.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
   localparam int ADDR_W = 6;
   localparam logic [ADDR_W-1:0] OFS_DOUT   = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_IOCFG  = 6'h04;
   localparam logic [ADDR_W-1:0] OFS_BLINK  = 6'h08;
   localparam logic [ADDR_W-1:0] OFS_POL    = 6'h0C;
   localparam logic [ADDR_W-1:0] OFS_DIN    = 6'h10;
   localparam logic [ADDR_W-1:0] OFS_CAUSE  = 6'h14;
   localparam logic [ADDR_W-1:0] OFS_EMASK  = 6'h18;
   localparam logic [ADDR_W-1:0] OFS_LMASK  = 6'h1C;
   localparam logic [ADDR_W-1:0] OFS_SEL    = 6'h20;
   localparam logic [ADDR_W-1:0] OFS_TIMERS = 6'h30;
   localparam int NSETS = 2;
endpackage

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] hi_len,
   input  logic [CW-1:0] lo_len,
   output logic          wave
);
   logic          phase_q;
   logic [CW-1:0] rem_q;
   logic [CW-1:0] next_len;
   logic [CW-1:0] next_eff;

   always_comb begin
      next_len = phase_q ? lo_len : hi_len;
      next_eff = (next_len == '0) ? CW'(1) : next_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b1;
         rem_q   <= '0;
      end else if (rem_q == '0) begin
         phase_q <= ~phase_q;
         rem_q   <= next_eff - CW'(1);
      end else begin
         rem_q <= rem_q - CW'(1);
      end
   end

   assign wave = phase_q;
endmodule

// File: rtl/gpio_blink_sync.sv
module gpio_blink_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st_q [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("gpio_blink_sync: STAGES must be at least 1");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[k] <= '0;
            else if (k == 0) st_q[k] <= d;
            else st_q[k] <= st_q[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_outmux.sv
module gpio_blink_outmux #(
   parameter int NLINES = 32,
   parameter int NSETS  = 2
) (
   input  logic [NLINES-1:0] static_val,
   input  logic [NLINES-1:0] blink_en,
   input  logic [NLINES-1:0] set_sel,
   input  logic [NSETS-1:0]  waves,
   output logic [NLINES-1:0] pad_out
);
   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         assign pad_out[i] = blink_en[i] ? waves[set_sel[i]] : static_val[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_blink_bank.sv
module gpio_blink_bank
   import gpio_blink_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [5:0]        bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [NLINES-1:0] pad_in,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_oe
);
   localparam int NL = NLINES;

   generate
      if (NLINES < 1 || NLINES > DW) begin : g_bad_lines
         $error("gpio_blink_bank: NLINES must be within 1..DW");
      end
      if (DW < 8) begin : g_bad_dw
         $error("gpio_blink_bank: DW too small");
      end
   endgenerate

   logic [NL-1:0] dout_q, iocfg_q, blink_q, pol_q, cause_q, emask_q, lmask_q, sel_q;
   logic [NL-1:0] din_sync;
   logic [DW-1:0] hi_q [NSETS];
   logic [DW-1:0] lo_q [NSETS];
   logic [NSETS-1:0] waves;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= '0;
         iocfg_q <= '1;
         blink_q <= '0;
         pol_q   <= '0;
         cause_q <= '0;
         emask_q <= '0;
         lmask_q <= '0;
         sel_q   <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFS_DOUT:  dout_q  <= bus_wdata[NL-1:0];
            OFS_IOCFG: iocfg_q <= bus_wdata[NL-1:0];
            OFS_BLINK: blink_q <= bus_wdata[NL-1:0];
            OFS_POL:   pol_q   <= bus_wdata[NL-1:0];
            OFS_CAUSE: cause_q <= cause_q & bus_wdata[NL-1:0];
            OFS_EMASK: emask_q <= bus_wdata[NL-1:0];
            OFS_LMASK: lmask_q <= bus_wdata[NL-1:0];
            OFS_SEL:   sel_q   <= bus_wdata[NL-1:0];
            default: ;
         endcase
      end
   end

   generate
      for (genvar s = 0; s < NSETS; s++) begin : g_set
         localparam logic [5:0] A_HI = OFS_TIMERS + 6'(s * 8);
         localparam logic [5:0] A_LO = OFS_TIMERS + 6'(s * 8 + 4);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q[s] <= DW'(1);
               lo_q[s] <= DW'(1);
            end else if (bus_wr) begin
               if (bus_addr == A_HI) hi_q[s] <= bus_wdata;
               if (bus_addr == A_LO) lo_q[s] <= bus_wdata;
            end
         end

         gpio_blink_timer #(.CW(DW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .hi_len (hi_q[s]),
            .lo_len (lo_q[s]),
            .wave   (waves[s])
         );
      end
   endgenerate

   gpio_blink_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (din_sync)
   );

   gpio_blink_outmux #(.NLINES(NL), .NSETS(NSETS)) u_mux (
      .static_val (dout_q),
      .blink_en   (blink_q),
      .set_sel    (sel_q),
      .waves      (waves),
      .pad_out    (pad_out)
   );

   assign pad_oe = ~iocfg_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_DOUT:  bus_rdata[NL-1:0] = dout_q;
         OFS_IOCFG: bus_rdata[NL-1:0] = iocfg_q;
         OFS_BLINK: bus_rdata[NL-1:0] = blink_q;
         OFS_POL:   bus_rdata[NL-1:0] = pol_q;
         OFS_DIN:   bus_rdata[NL-1:0] = din_sync ^ pol_q;
         OFS_CAUSE: bus_rdata[NL-1:0] = cause_q;
         OFS_EMASK: bus_rdata[NL-1:0] = emask_q;
         OFS_LMASK: bus_rdata[NL-1:0] = lmask_q;
         OFS_SEL:   bus_rdata[NL-1:0] = sel_q;
         default: ;
      endcase
      for (int s = 0; s < NSETS; s++) begin
         if (bus_addr == OFS_TIMERS + 6'(s * 8))     bus_rdata = hi_q[s];
         if (bus_addr == OFS_TIMERS + 6'(s * 8 + 4)) bus_rdata = lo_q[s];
      end
   end
endmodule

// File: rtl/gpio_blink_bank_chk.sv
module gpio_blink_bank_chk
   import gpio_blink_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [5:0]        bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic [NLINES-1:0] pad_in,
   input logic [NLINES-1:0] pad_out,
   input logic [NLINES-1:0] pad_oe,
   input logic [NLINES-1:0] blink_q,
   input logic [NLINES-1:0] sel_q,
   input logic [NLINES-1:0] cause_q,
   input logic [NLINES-1:0] din_sync
);
   logic [1:0] cyc_q;
   logic [NLINES-1:0] on_a, on_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_q <= '0;
      else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
   end

   assign on_a = blink_q & ~sel_q;
   assign on_b = blink_q & sel_q;

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_IOCFG) |=> (pad_oe == ~$past(bus_wdata[NLINES-1:0]))); // R3

   AST_STATIC_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DOUT && blink_q == '0) |=> (pad_out == $past(bus_wdata[NLINES-1:0]))); // R4

   AST_SET_A_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & on_a) == '0) || ((pad_out & on_a) == on_a)); // R9

   AST_SET_B_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & on_b) == '0) || ((pad_out & on_b) == on_b)); // R9

   AST_CAUSE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q != 2'd0) |-> ((cause_q & ~$past(cause_q)) == '0)); // R10

   AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_STAGES == 2 && cyc_q >= 2'd2) |-> (din_sync == $past(pad_in, 2))); // R5
endmodule

bind gpio_blink_bank gpio_blink_bank_chk #(
   .NLINES(NLINES), .DW(DW), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .blink_q   (blink_q),
   .sel_q     (sel_q),
   .cause_q   (cause_q),
   .din_sync  (din_sync)
);

// File: tb/sim_gpio_blink_bank.sv
module sim_gpio_blink_bank;
   localparam int NL = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] pad_in = '0;
   logic [NL-1:0] pad_out;
   logic [NL-1:0] pad_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_blink_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_rise(input int line);
      logic prev;
      prev = pad_out[line];
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (!prev && pad_out[line]) return;
         prev = pad_out[line];
      end
   endtask

   task automatic count_run(input int line, input logic lvl, inout int n);
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (pad_out[line] !== lvl) return;
         n++;
      end
   endtask

   task automatic measure(input int line, input int exp_hi, input int exp_lo, input string tag);
      int hi, lo;
      wait_rise(line);
      hi = 1; lo = 1;
      count_run(line, 1'b1, hi);
      count_run(line, 1'b0, lo);
      chk(32'(hi), 32'(exp_hi), {tag, " high length"});
      chk(32'(lo), 32'(exp_lo), {tag, " low length"});
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk(pad_oe, 32'h0, "R1 pad_oe at reset");
      chk(pad_out, 32'h0, "R1 pad_out at reset");
      rd(6'h04, d); chk(d, 32'hFFFF_FFFF, "R1 direction reset");
      rd(6'h08, d); chk(d, 32'h0, "R1 blink enable reset");
      rd(6'h30, d); chk(d, 32'h1, "R1 set A high length reset");
      rd(6'h3C, d); chk(d, 32'h1, "R1 set B low length reset");
   endtask

   task automatic t_regs;
      logic [31:0] d;
      wr(6'h20, 32'h1234_5678); rd(6'h20, d); chk(d, 32'h1234_5678, "R2 select readback");
      wr(6'h18, 32'hA5A5_0001); rd(6'h18, d); chk(d, 32'hA5A5_0001, "R2 mask 0x18 readback");
      wr(6'h1C, 32'h0F0F_8000); rd(6'h1C, d); chk(d, 32'h0F0F_8000, "R2 mask 0x1C readback");
      wr(6'h38, 32'h0000_0123); rd(6'h38, d); chk(d, 32'h0000_0123, "R2 set B high readback");
      wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); chk(d, 32'h0, "R2 unmapped reads 0");
      wr(6'h20, 32'h0);
   endtask

   task automatic t_dir;
      wr(6'h04, 32'hFFFF_0000);
      chk(pad_oe, 32'h0000_FFFF, "R3 output enables follow direction");
      wr(6'h04, 32'h0);
      chk(pad_oe, 32'hFFFF_FFFF, "R3 all outputs");
   endtask

   task automatic t_static;
      wr(6'h00, 32'hCAFE_0001);
      chk(pad_out, 32'hCAFE_0001, "R4 static output");
      wr(6'h00, 32'h0);
      chk(pad_out, 32'h0, "R4 static output cleared");
   endtask

   task automatic t_din;
      logic [31:0] d;
      @(negedge clk);
      pad_in = 32'hA5A5_0F0F;
      @(negedge clk);
      rd(6'h10, d); chk(d, 32'h0, "R5 input not yet visible after one edge");
      @(negedge clk);
      rd(6'h10, d); chk(d, 32'hA5A5_0F0F, "R5 input visible after two edges");
      wr(6'h0C, 32'hFFFF_0000);
      rd(6'h10, d); chk(d, 32'h5A5A_0F0F, "R5 polarity applied");
      wr(6'h10, 32'hFFFF_FFFF);
      rd(6'h10, d); chk(d, 32'h5A5A_0F0F, "R11 input data write ignored");
      wr(6'h0C, 32'h0);
   endtask

   task automatic t_cause;
      logic [31:0] d;
      wr(6'h14, 32'hFFFF_FFFF); rd(6'h14, d); chk(d, 32'h0, "R10 ones do not set cause");
      wr(6'h14, 32'h0);         rd(6'h14, d); chk(d, 32'h0, "R10 zeros clear cause");
   endtask

   task automatic t_blink;
      wr(6'h30, 32'd3); wr(6'h34, 32'd2);
      wr(6'h38, 32'd4); wr(6'h3C, 32'd4);
      wr(6'h20, 32'h0000_0004);
      wr(6'h08, 32'h0000_0006);
      measure(1, 3, 2, "R6 R7 line 1 on set A");
      measure(2, 4, 4, "R7 line 2 on set B");
      chk(32'(pad_out[0]), 32'h0, "R4 line 0 stays static");
   endtask

   task automatic t_zero;
      logic [31:0] d;
      wr(6'h30, 32'd0); wr(6'h34, 32'd0);
      rd(6'h30, d); chk(d, 32'h0, "R2 zero length stored");
      measure(1, 1, 1, "R6 zero length acts as one");
   endtask

   task automatic t_phase;
      int bad;
      bad = 0;
      wr(6'h20, 32'h0000_0024);
      wr(6'h08, 32'h0000_0024);
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         if (pad_out[2] !== pad_out[5]) bad++;
      end
      chk(32'(bad), 32'h0, "R9 lines on set B in phase");
   endtask

   task automatic t_boundary;
      int hi, lo, hi2;
      wr(6'h20, 32'h0);
      wr(6'h08, 32'h0000_0002);
      wr(6'h30, 32'd6); wr(6'h34, 32'd6);
      measure(1, 6, 6, "R6 settled 6/6");
      wait_rise(1);
      bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 32'd2;
      hi = 1; lo = 1; hi2 = 1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (pad_out[1] === 1'b1) hi++;
      count_run(1, 1'b1, hi);
      count_run(1, 1'b0, lo);
      count_run(1, 1'b1, hi2);
      chk(32'(hi), 32'd6, "R8 running phase keeps old length");
      chk(32'(lo), 32'd6, "R8 low length unchanged");
      chk(32'(hi2), 32'd2, "R8 new length at next phase");
   endtask

   task automatic t_disable;
      wr(6'h08, 32'h0);
      wr(6'h00, 32'h0000_0002);
      chk(pad_out, 32'h0000_0002, "R4 static path after blink off");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_dir;
      t_static;
      t_din;
      t_cause;
      t_blink;
      t_zero;
      t_phase;
      t_boundary;
      t_disable;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule